// File: doc/BRIEF.md
# Real-Time Clock Calendar with Maskable Alarm

This block keeps wall-clock time and date for a chip that owns a slow time base. A strobe input, pulsed at 128 Hz from a 32.768 kHz source, drives a sub-second divider. The divider advances a calendar of seconds, minutes, hours, day of month, month and two-digit year. The calendar handles month lengths and February in leap years on its own.

Software talks to the block through a byte-wide register port. Every time, date and alarm field is read and written in BCD. The hour field follows a control bit that selects either a 24-hour format or a 12-hour format with a PM flag. An alarm compares selected fields against the current time after each seconds advance and raises a sticky flag. A separate tick output pulses at one of eight power-of-two fractions of a second.

Top module: `rtc_cal`

## Requirements
- R1: After reset: seconds, minutes, hours and year read 00; day and month read 01. All alarm fields, the alarm mask, the control register and the status register read 00. tick_o and alarm_o are low.
- R2: Register addresses are 0 second, 1 minute, 2 hour, 3 day, 4 month, 5 year, 6 to 11 the alarm fields in the same field order, 12 alarm mask, 13 control and 14 status. Field registers hold two BCD digits, the tens digit in bits 7:4. A written value reads back unchanged.
- R3: Seconds advance by one on every 128th strobe. Any write to addresses 0 to 5 clears the sub-second divider, so the next advance comes on the 128th strobe after that write.
- R4: Seconds and minutes wrap from 59 to 00 and carry into the next field. Hours wrap from 23 to 00 and carry into the day.
- R5: Day wraps to 01 after the last day of the month. April, June, September and November have 30 days and the other months 31, except February. February has 29 days when the year value is divisible by 4 (00 included) and 28 otherwise. December rolls to January and increments the year, and year 99 rolls to 00.
- R6: Control bit 0 set selects 12-hour format for the hour and alarm-hour registers, for both reads and writes. In that format bit 7 is PM and bits 5:0 hold BCD 01 to 12. Midnight reads 0x12, noon reads 0x92, and 13:00 reads 0x81.
- R7: The alarm compares only in the cycle after a seconds advance. If every unmasked field matches, status bit 0 and alarm_o go high and stay high until 1 is written to status bit 0. A time set equal to the alarm without a seconds advance does not set the flag.
- R8: Alarm mask bit n (0 second, 1 minute, 2 hour, 3 day, 4 month, 5 year) set to 1 excludes that field from the comparison.
- R9: With control bits 3:1 equal to s, tick_o gives a one-cycle pulse once every 2^s strobes, counted from the last divider clear. For s = 7 this is once per second.
- R10: A mismatch in any unmasked field has no effect on the alarm flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | 128 Hz enable, one cycle wide |
| wr_en_i | input | 1 | Register write enable |
| addr_i | input | 4 | Register address for read and write |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for addr_i, combinational |
| tick_o | output | 1 | Periodic sub-second tick pulse |
| alarm_o | output | 1 | Sticky alarm flag |

## Verification
The bench builds the block with the default divider width of 7, which gives 128 strobes per second and eight tick rates. It holds the strobe high every clock while it counts, so one second takes 128 cycles. Each rollover test presets the time one second before a boundary: month end, leap and common February, year 00, year 99, and the 11 PM to 12 AM change in 12-hour format. These boundaries can then be reached and checked within a few hundred cycles. The tick is counted over a fixed window for the fastest, a middle and the slowest rate.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef struct packed {
    logic [6:0] yr;
    logic [3:0] mon;
    logic [4:0] day;
    logic [4:0] hr;
    logic [5:0] mn;
    logic [5:0] sc;
  } rtc_time_t;

  localparam int unsigned FIELDS = 6;

  typedef enum logic [3:0] {
    A_SEC = 4'd0, A_MIN = 4'd1, A_HR = 4'd2, A_DAY = 4'd3, A_MON = 4'd4, A_YR = 4'd5,
    A_ASEC = 4'd6, A_AMIN = 4'd7, A_AHR = 4'd8, A_ADAY = 4'd9, A_AMON = 4'd10, A_AYR = 4'd11,
    A_MASK = 4'd12, A_CTRL = 4'd13, A_STAT = 4'd14, A_NONE = 4'd15
  } reg_addr_e;

  function automatic logic [6:0] bcd2bin(logic [7:0] b);
    return ({3'b0, b[7:4]} * 7'd10) + {3'b0, b[3:0]};
  endfunction

  function automatic logic [7:0] bin2bcd(logic [6:0] v);
    logic [6:0] t, o;
    t = v / 7'd10;
    o = v - t * 7'd10;
    return {t[3:0], o[3:0]};
  endfunction

  function automatic logic [4:0] days_in_month(logic [3:0] m, logic [6:0] y);
    case (m)
      4'd2:                      return (y[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction

  function automatic logic [7:0] hr_to_reg(logic [4:0] h, logic m12);
    logic [4:0] h12;
    logic [7:0] b;
    if (!m12) return bin2bcd({2'b0, h});
    h12 = (h >= 5'd12) ? h - 5'd12 : h;
    if (h12 == 5'd0) h12 = 5'd12;
    b = bin2bcd({2'b0, h12});
    return {h >= 5'd12, 1'b0, b[5:0]};
  endfunction

  function automatic logic [4:0] reg_to_hr(logic [7:0] d, logic m12);
    logic [6:0] v;
    logic [4:0] h;
    if (!m12) begin
      v = bcd2bin(d);
      return v[4:0];
    end
    v = bcd2bin({2'b0, d[5:0]});
    h = (v == 7'd12) ? 5'd0 : v[4:0];
    if (d[7]) h = h + 5'd12;
    return h;
  endfunction
endpackage

// File: rtl/rtc_subsec.sv
module rtc_subsec #(
  parameter int unsigned SUB_W = 7,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             sec_step_o,
  output logic             tick_o
);
  logic [SUB_W-1:0] div_q, sel_mask;
  logic             tick_q;

  assign sel_mask   = SUB_W'((32'd1 << sel_i) - 32'd1);
  assign sec_step_o = strobe_i & (&div_q) & ~clr_i;
  assign tick_o     = tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= strobe_i & ~clr_i & ((div_q & sel_mask) == sel_mask);
      if (clr_i)         div_q <= '0;
      else if (strobe_i) div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      step_i,
  input  logic      wr_en_i,
  input  reg_addr_e addr_i,
  input  logic [7:0] wr_data_i,
  input  logic      mode12_i,
  output rtc_time_t now_o,
  output logic      time_wr_o
);
  rtc_time_t  t_q;
  logic [4:0] dim;
  logic [6:0] wv;

  assign dim       = days_in_month(t_q.mon, t_q.yr);
  assign wv        = bcd2bin(wr_data_i);
  assign time_wr_o = wr_en_i && (addr_i inside {A_SEC, A_MIN, A_HR, A_DAY, A_MON, A_YR});
  assign now_o     = t_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q <= '{yr: 7'd0, mon: 4'd1, day: 5'd1, hr: 5'd0, mn: 6'd0, sc: 6'd0};
    end else if (time_wr_o) begin
      case (addr_i)
        A_SEC:   t_q.sc  <= wv[5:0];
        A_MIN:   t_q.mn  <= wv[5:0];
        A_HR:    t_q.hr  <= reg_to_hr(wr_data_i, mode12_i);
        A_DAY:   t_q.day <= wv[4:0];
        A_MON:   t_q.mon <= wv[3:0];
        A_YR:    t_q.yr  <= wv;
        default: ;
      endcase
    end else if (step_i) begin
      if (t_q.sc != 6'd59) t_q.sc <= t_q.sc + 6'd1;
      else begin
        t_q.sc <= 6'd0;
        if (t_q.mn != 6'd59) t_q.mn <= t_q.mn + 6'd1;
        else begin
          t_q.mn <= 6'd0;
          if (t_q.hr != 5'd23) t_q.hr <= t_q.hr + 5'd1;
          else begin
            t_q.hr <= 5'd0;
            if (t_q.day != dim) t_q.day <= t_q.day + 5'd1;
            else begin
              t_q.day <= 5'd1;
              if (t_q.mon != 4'd12) t_q.mon <= t_q.mon + 4'd1;
              else begin
                t_q.mon <= 4'd1;
                t_q.yr  <= (t_q.yr == 7'd99) ? 7'd0 : t_q.yr + 7'd1;
              end
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  rtc_time_t         now_i,
  input  logic              wr_en_i,
  input  reg_addr_e         addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              mode12_i,
  output rtc_time_t         alm_o,
  output logic [FIELDS-1:0] mask_o,
  output logic              flag_o
);
  rtc_time_t         alm_q;
  logic [FIELDS-1:0] mask_q, match;
  logic              step_q, flag_q;
  logic [6:0]        cur_f [FIELDS];
  logic [6:0]        alm_f [FIELDS];
  logic [6:0]        wv;

  assign wv = bcd2bin(wr_data_i);

  assign cur_f[0] = {1'b0, now_i.sc};  assign alm_f[0] = {1'b0, alm_q.sc};
  assign cur_f[1] = {1'b0, now_i.mn};  assign alm_f[1] = {1'b0, alm_q.mn};
  assign cur_f[2] = {2'b0, now_i.hr};  assign alm_f[2] = {2'b0, alm_q.hr};
  assign cur_f[3] = {2'b0, now_i.day}; assign alm_f[3] = {2'b0, alm_q.day};
  assign cur_f[4] = {3'b0, now_i.mon}; assign alm_f[4] = {3'b0, alm_q.mon};
  assign cur_f[5] = now_i.yr;          assign alm_f[5] = alm_q.yr;

  for (genvar i = 0; i < FIELDS; i++) begin : g_cmp
    assign match[i] = mask_q[i] | (cur_f[i] == alm_f[i]);
  end

  assign alm_o  = alm_q;
  assign mask_o = mask_q;
  assign flag_o = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_q  <= '0;
      mask_q <= '0;
      step_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      step_q <= step_i;
      if (wr_en_i) begin
        case (addr_i)
          A_ASEC:  alm_q.sc  <= wv[5:0];
          A_AMIN:  alm_q.mn  <= wv[5:0];
          A_AHR:   alm_q.hr  <= reg_to_hr(wr_data_i, mode12_i);
          A_ADAY:  alm_q.day <= wv[4:0];
          A_AMON:  alm_q.mon <= wv[3:0];
          A_AYR:   alm_q.yr  <= wv;
          A_MASK:  mask_q    <= wr_data_i[FIELDS-1:0];
          default: ;
        endcase
      end
      // a match on this cycle wins over a clear written in the same cycle
      if (step_q && (&match))                            flag_q <= 1'b1;
      else if (wr_en_i && addr_i == A_STAT && wr_data_i[0]) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_cal.sv
module rtc_cal
  import rtc_pkg::*;
#(
  parameter int unsigned SUB_W = 7,
  localparam int unsigned SEL_W = $clog2(SUB_W + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       strobe_i,
  input  logic       wr_en_i,
  input  logic [3:0] addr_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  output logic       tick_o,
  output logic       alarm_o
);
  reg_addr_e         addr;
  rtc_time_t         now_w, alm_w;
  logic [FIELDS-1:0] mask_w;
  logic              mode12_q, time_wr, sec_step, flag_w;
  logic [SEL_W-1:0]  sel_q;

  assign addr    = reg_addr_e'(addr_i);
  assign alarm_o = flag_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode12_q <= 1'b0;
      sel_q    <= '0;
    end else if (wr_en_i && addr == A_CTRL) begin
      mode12_q <= wr_data_i[0];
      sel_q    <= wr_data_i[SEL_W:1];
    end
  end

  rtc_subsec #(.SUB_W(SUB_W), .SEL_W(SEL_W)) u_subsec (
    .clk_i, .rst_ni, .strobe_i, .clr_i(time_wr), .sel_i(sel_q),
    .sec_step_o(sec_step), .tick_o
  );

  rtc_calendar u_cal (
    .clk_i, .rst_ni, .step_i(sec_step), .wr_en_i, .addr_i(addr), .wr_data_i,
    .mode12_i(mode12_q), .now_o(now_w), .time_wr_o(time_wr)
  );

  rtc_alarm u_alarm (
    .clk_i, .rst_ni, .step_i(sec_step), .now_i(now_w), .wr_en_i, .addr_i(addr),
    .wr_data_i, .mode12_i(mode12_q), .alm_o(alm_w), .mask_o(mask_w), .flag_o(flag_w)
  );

  always_comb begin
    case (addr)
      A_SEC:   rd_data_o = bin2bcd({1'b0, now_w.sc});
      A_MIN:   rd_data_o = bin2bcd({1'b0, now_w.mn});
      A_HR:    rd_data_o = hr_to_reg(now_w.hr, mode12_q);
      A_DAY:   rd_data_o = bin2bcd({2'b0, now_w.day});
      A_MON:   rd_data_o = bin2bcd({3'b0, now_w.mon});
      A_YR:    rd_data_o = bin2bcd(now_w.yr);
      A_ASEC:  rd_data_o = bin2bcd({1'b0, alm_w.sc});
      A_AMIN:  rd_data_o = bin2bcd({1'b0, alm_w.mn});
      A_AHR:   rd_data_o = hr_to_reg(alm_w.hr, mode12_q);
      A_ADAY:  rd_data_o = bin2bcd({2'b0, alm_w.day});
      A_AMON:  rd_data_o = bin2bcd({3'b0, alm_w.mon});
      A_AYR:   rd_data_o = bin2bcd(alm_w.yr);
      A_MASK:  rd_data_o = 8'(mask_w);
      A_CTRL:  rd_data_o = 8'({sel_q, mode12_q});
      A_STAT:  rd_data_o = {7'b0, flag_w};
      default: rd_data_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/rtc_cal_chk.sv
module rtc_cal_chk
  import rtc_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       strobe_i,
  input logic       wr_en_i,
  input logic [3:0] addr_i,
  input logic       clr_bit_i,
  input logic       tick_o,
  input logic       alarm_o,
  input rtc_time_t  now_i
);
  a_r4_time_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    now_i.sc < 6'd60 && now_i.mn < 6'd60 && now_i.hr < 5'd24);

  a_r5_date_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    now_i.day >= 5'd1 && now_i.day <= 5'd31 && now_i.mon >= 4'd1 &&
    now_i.mon <= 4'd12 && now_i.yr <= 7'd99);

  a_r3_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_i && !wr_en_i) |=> $stable(now_i));

  a_r7_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_o && !(wr_en_i && addr_i == 4'd14 && clr_bit_i)) |=> alarm_o);

  a_r7_flag_after_second: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_o) |-> $past(strobe_i, 2));

  a_r9_tick_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> $past(strobe_i));
endmodule

bind rtc_cal rtc_cal_chk u_chk (
  .clk_i, .rst_ni, .strobe_i, .wr_en_i, .addr_i, .clr_bit_i(wr_data_i[0]),
  .tick_o, .alarm_o, .now_i(now_w)
);

// File: tb/rtc_cal_bench.sv
module rtc_cal_bench;
  localparam int CLK_P = 10;

  logic       clk_i = 1'b0, rst_ni = 1'b0, strobe_i = 1'b0, wr_en_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic       tick_o, alarm_o;
  int n_chk = 0, n_fail = 0, tick_cnt = 0;
  bit done = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  rtc_cal u_rtc_cal (.*);

  always @(negedge clk_i) if (tick_o) tick_cnt++;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rd_data_o;
  endtask

  task automatic rd_chk(string req, logic [3:0] a, logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic run(int n);
    @(negedge clk_i);
    strobe_i = 1'b1;
    tick_cnt = 0;
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
    strobe_i = 1'b0;
  endtask

  task automatic set_time(logic [7:0] y, logic [7:0] mo, logic [7:0] d,
                          logic [7:0] h, logic [7:0] mi, logic [7:0] s);
    wr(4'd5, y); wr(4'd4, mo); wr(4'd3, d); wr(4'd2, h); wr(4'd1, mi); wr(4'd0, s);
  endtask

  task automatic t_reset;
    rd_chk("R1 sec", 4'd0, 8'h00);  rd_chk("R1 min", 4'd1, 8'h00);
    rd_chk("R1 hour", 4'd2, 8'h00); rd_chk("R1 day", 4'd3, 8'h01);
    rd_chk("R1 month", 4'd4, 8'h01); rd_chk("R1 year", 4'd5, 8'h00);
    for (int a = 6; a <= 14; a++) rd_chk("R1 alarm/ctrl/status", 4'(a), 8'h00);
    check("R1 tick_o", {7'b0, tick_o}, 8'h00);
    check("R1 alarm_o", {7'b0, alarm_o}, 8'h00);
    wr(4'd0, 8'h45); rd_chk("R2 sec readback", 4'd0, 8'h45);
    wr(4'd9, 8'h27); rd_chk("R2 alarm day readback", 4'd9, 8'h27);
  endtask

  task automatic t_second;
    set_time(8'h25, 8'h03, 8'h14, 8'h10, 8'h20, 8'h30);
    run(127); rd_chk("R3 no advance at 127", 4'd0, 8'h30);
    run(1);   rd_chk("R3 advance at 128", 4'd0, 8'h31);
    run(100); wr(4'd0, 8'h10);
    run(127); rd_chk("R3 write clears divider", 4'd0, 8'h10);
    run(1);   rd_chk("R3 advance after write", 4'd0, 8'h11);
  endtask

  task automatic t_carry;
    set_time(8'h24, 8'h06, 8'h15, 8'h10, 8'h59, 8'h59);
    run(128);
    rd_chk("R4 hour carry", 4'd2, 8'h11); rd_chk("R4 min wrap", 4'd1, 8'h00);
    rd_chk("R4 sec wrap", 4'd0, 8'h00);
    set_time(8'h24, 8'h06, 8'h15, 8'h23, 8'h59, 8'h59);
    run(128);
    rd_chk("R4 hour wrap", 4'd2, 8'h00); rd_chk("R4 day carry", 4'd3, 8'h16);
  endtask

  task automatic roll(string req, logic [7:0] y, logic [7:0] mo, logic [7:0] d,
                      logic [7:0] ey, logic [7:0] emo, logic [7:0] ed);
    set_time(y, mo, d, 8'h23, 8'h59, 8'h59);
    run(128);
    rd_chk(req, 4'd3, ed); rd_chk(req, 4'd4, emo); rd_chk(req, 4'd5, ey);
  endtask

  task automatic t_calendar;
    roll("R5 leap feb 28", 8'h24, 8'h02, 8'h28, 8'h24, 8'h02, 8'h29);
    roll("R5 leap feb 29", 8'h24, 8'h02, 8'h29, 8'h24, 8'h03, 8'h01);
    roll("R5 common feb",  8'h23, 8'h02, 8'h28, 8'h23, 8'h03, 8'h01);
    roll("R5 year 00 leap", 8'h00, 8'h02, 8'h28, 8'h00, 8'h02, 8'h29);
    roll("R5 april 30",    8'h25, 8'h04, 8'h30, 8'h25, 8'h05, 8'h01);
    roll("R5 january 30",  8'h25, 8'h01, 8'h30, 8'h25, 8'h01, 8'h31);
    roll("R5 year 99 wrap", 8'h99, 8'h12, 8'h31, 8'h00, 8'h01, 8'h01);
  endtask

  task automatic t_h12;
    wr(4'd13, 8'h00); wr(4'd2, 8'h00); wr(4'd13, 8'h01);
    rd_chk("R6 midnight 12 AM", 4'd2, 8'h12);
    wr(4'd13, 8'h00); wr(4'd2, 8'h13); wr(4'd13, 8'h01);
    rd_chk("R6 13h reads 1 PM", 4'd2, 8'h81);
    wr(4'd13, 8'h00); wr(4'd2, 8'h12); wr(4'd13, 8'h01);
    rd_chk("R6 noon 12 PM", 4'd2, 8'h92);
    wr(4'd2, 8'h87); rd_chk("R6 12h write readback", 4'd2, 8'h87);
    wr(4'd13, 8'h00); rd_chk("R6 7 PM as 24h", 4'd2, 8'h19);
    wr(4'd13, 8'h01);
    set_time(8'h25, 8'h05, 8'h10, 8'h91, 8'h59, 8'h59);
    run(128);
    rd_chk("R6 11 PM to 12 AM", 4'd2, 8'h12); rd_chk("R6 day carry 12h", 4'd3, 8'h11);
    set_time(8'h25, 8'h05, 8'h10, 8'h11, 8'h59, 8'h59);
    run(128);
    rd_chk("R6 11 AM to 12 PM", 4'd2, 8'h92);
    wr(4'd13, 8'h00);
  endtask

  task automatic set_alarm(logic [7:0] y, logic [7:0] s, logic [7:0] mi, logic [7:0] m);
    wr(4'd11, y); wr(4'd10, 8'h03); wr(4'd9, 8'h14); wr(4'd8, 8'h10);
    wr(4'd7, mi); wr(4'd6, s); wr(4'd12, m); wr(4'd14, 8'h01);
  endtask

  task automatic t_alarm;
    set_alarm(8'h25, 8'h31, 8'h20, 8'h00);
    set_time(8'h25, 8'h03, 8'h14, 8'h10, 8'h20, 8'h31);
    repeat (4) @(negedge clk_i);
    rd_chk("R7 no compare without advance", 4'd14, 8'h00);
    set_time(8'h25, 8'h03, 8'h14, 8'h10, 8'h20, 8'h30);
    run(128);
    rd_chk("R7 flag set", 4'd14, 8'h01);
    check("R7 alarm_o high", {7'b0, alarm_o}, 8'h01);
    run(128);
    repeat (5) @(negedge clk_i);
    rd_chk("R7 flag sticky", 4'd14, 8'h01);
    wr(4'd14, 8'h01);
    rd_chk("R7 flag cleared", 4'd14, 8'h00);
    check("R7 alarm_o cleared", {7'b0, alarm_o}, 8'h00);
  endtask

  task automatic t_mask;
    set_alarm(8'h26, 8'h31, 8'h20, 8'h00);
    set_time(8'h25, 8'h03, 8'h14, 8'h10, 8'h20, 8'h30);
    run(128); rd_chk("R10 year mismatch no flag", 4'd14, 8'h00);
    check("R10 alarm_o low", {7'b0, alarm_o}, 8'h00);
    set_alarm(8'h26, 8'h31, 8'h20, 8'h20);
    set_time(8'h25, 8'h03, 8'h14, 8'h10, 8'h20, 8'h30);
    run(128); rd_chk("R8 year masked", 4'd14, 8'h01);
    set_alarm(8'h25, 8'h31, 8'h20, 8'h01);
    set_time(8'h25, 8'h03, 8'h14, 8'h10, 8'h20, 8'h50);
    run(128); rd_chk("R8 second masked", 4'd14, 8'h01);
    set_alarm(8'h25, 8'h31, 8'h20, 8'h01);
    set_time(8'h25, 8'h03, 8'h14, 8'h10, 8'h21, 8'h50);
    run(128); rd_chk("R10 minute mismatch no flag", 4'd14, 8'h00);
    rd_chk("R8 mask readback", 4'd12, 8'h01);
  endtask

  task automatic tick_case(string req, logic [7:0] ctrl, int n, int exp);
    wr(4'd13, ctrl); wr(4'd0, 8'h00);
    run(n);
    @(negedge clk_i); #1;
    check(req, 8'(tick_cnt), 8'(exp));
  endtask

  task automatic t_tick;
    tick_case("R9 sel 0 every strobe", 8'h00, 64, 64);
    tick_case("R9 sel 2 every 4", 8'h04, 64, 16);
    tick_case("R9 sel 7 once per second", 8'h0E, 256, 2);
    rd_chk("R9 ctrl readback", 4'd13, 8'h0E);
    wr(4'd13, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset; t_second; t_carry; t_calendar; t_h12; t_alarm; t_mask; t_tick;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule